// File: doc/BRIEF.md
# Phase-latched register write-strobe decoder

This block turns the encoded destination fields of a micro-instruction into individual write strobes for a register file. A 4-bit write-select code picks one destination register, with one code reserved for "no destination" and the top code reserved for an external memory write. A 2-bit incrementer-select code picks which address register takes the incremented address. Two direct load bits carry the opcode-register load and the pointer high-byte load.

A system clock runs the block, and a phase input marks the second half of each machine cycle. The decoded strobes are captured once, on the first clock edge of phase 2, so later changes in the control fields cannot cause glitches. They are released as single-clock commit pulses right after phase 2 ends, so the registers update at the end of the phase. A memory write pulls the active-low read/write line low for the length of phase 2, unless the bus enable is deasserted. An inhibit-prefetch input masks every program-counter write. The two bus-source select outputs for the program counter and the data pointer follow the incrementer field directly and are not latched.

Top module: `wr_strobe_latch`

## Requirements
- R1: Write-select codes 1 to 14 give a one-clock pulse on `reg_we_o` bit (code-1), in the cycle after the first clock edge that samples `ph2_i` low following phase 2. Code 0 gives no strobe.
- R2: Write-select code 15 gives no register strobe. It requests a memory write instead.
- R3: The control inputs are captured on the first clock edge that samples `ph2_i` high. Changes to them during the rest of phase 2 have no effect on the strobes produced.
- R4: For a captured memory write, `rw_n_o` is low from the cycle after capture until the edge that samples `ph2_i` low. It is therefore low for as many cycles as phase 2 lasted, shifted by one clock.
- R5: While the captured `inhpf_i` is high, no program-counter write occurs. The PC is write-select code 1 and incrementer-select code 1.
- R6: `pc_sw_o` is high exactly while `isel_i` is 1. `dp_sw_o` is high exactly while `isel_i` is 2. Both are combinational.
- R7: Incrementer-select codes 1, 2 and 3 pulse `inc_we_o` bit 0 (PC), bit 1 (data pointer low) and bit 2 (stack pointer). They use the same timing as R1. Code 0 gives nothing.
- R8: `ir_ld_i` and `dph_ld_i` are captured like the decoded strobes and appear as one-clock pulses on `ir_ld_o` and `dph_ld_o` with the timing of R1.
- R9: At most one bit of `reg_we_o` is high in any cycle, and none is high outside a commit cycle.
- R10: While `be_ni` is high, `rw_n_o` stays high.
- R11: During reset, all strobes are low, `rw_n_o` is high and no phase is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ph2_i | input | 1 | High during clock phase 2 |
| wsel_i | input | 4 | Write-select code (0 none, 1..14 register, 15 memory) |
| isel_i | input | 2 | Incrementer target (0 none, 1 PC, 2 DP low, 3 SP) |
| inhpf_i | input | 1 | Inhibit prefetch: masks PC writes |
| ir_ld_i | input | 1 | Opcode register parallel load |
| dph_ld_i | input | 1 | Pointer high byte parallel load |
| be_ni | input | 1 | Active-low bus enable |
| reg_we_o | output | 14 | Per-register commit strobes |
| inc_we_o | output | 3 | Incremented-value commit strobes |
| ir_ld_o | output | 1 | Opcode register load strobe |
| dph_ld_o | output | 1 | Pointer high byte load strobe |
| rw_n_o | output | 1 | Active-low memory write line |
| pc_sw_o | output | 1 | PC input mux select (unlatched) |
| dp_sw_o | output | 1 | DP input mux select (unlatched) |

## Verification
The embedded assertions check on every cycle that the register strobes stay one-hot-or-zero and appear only just after a phase 2 falling edge. They also check that strobes never last more than one clock, and that the read/write line goes low only inside a phase and only with the bus enabled. Only the bench's scenarios can show that the right bit is chosen for each code and that inputs changed mid-phase are ignored. The scenarios also cover the inhibit masking on both program-counter paths and the exact length of the read/write low window.

// File: rtl/wr_strobe_latch.sv
module wr_strobe_latch #(
  parameter int SEL_W   = 4,
  parameter int PC_CODE = 1,
  localparam int NREG   = (1 << SEL_W) - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ph2_i,
  input  logic [SEL_W-1:0] wsel_i,
  input  logic [1:0]       isel_i,
  input  logic             inhpf_i,
  input  logic             ir_ld_i,
  input  logic             dph_ld_i,
  input  logic             be_ni,
  output logic [NREG-1:0]  reg_we_o,
  output logic [2:0]       inc_we_o,
  output logic             ir_ld_o,
  output logic             dph_ld_o,
  output logic             rw_n_o,
  output logic             pc_sw_o,
  output logic             dp_sw_o
);
  localparam logic [SEL_W-1:0] MEM_CODE = '1;

  logic [NREG-1:0] dec_reg, cap_reg;
  logic [2:0]      dec_inc, cap_inc;
  logic            cap_ir, cap_dph, cap_mem, ph2_q, act_q;
  logic            start, finish;

  always_comb begin
    dec_reg = '0;
    for (int k = 1; k <= NREG; k++)
      if (wsel_i == SEL_W'(k)) dec_reg[k-1] = 1'b1;
    if (inhpf_i) dec_reg[PC_CODE-1] = 1'b0;
  end

  assign dec_inc = {isel_i == 2'd3, isel_i == 2'd2, (isel_i == 2'd1) & ~inhpf_i};
  assign start   = ph2_i & ~ph2_q;
  assign finish  = ph2_q & ~ph2_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ph2_q <= 1'b0; act_q <= 1'b0;
      cap_reg <= '0; cap_inc <= '0; cap_ir <= 1'b0; cap_dph <= 1'b0; cap_mem <= 1'b0;
      reg_we_o <= '0; inc_we_o <= '0; ir_ld_o <= 1'b0; dph_ld_o <= 1'b0;
    end else begin
      ph2_q <= ph2_i;
      if (start) begin
        act_q   <= 1'b1;
        cap_reg <= dec_reg;
        cap_inc <= dec_inc;
        cap_ir  <= ir_ld_i;
        cap_dph <= dph_ld_i;
        cap_mem <= (wsel_i == MEM_CODE);
      end else if (finish) begin
        act_q <= 1'b0;
      end
      reg_we_o <= finish ? cap_reg : '0;
      inc_we_o <= finish ? cap_inc : '0;
      ir_ld_o  <= finish & cap_ir;
      dph_ld_o <= finish & cap_dph;
    end
  end

  assign rw_n_o  = ~(act_q & cap_mem & ~be_ni);
  assign pc_sw_o = (isel_i == 2'd1);
  assign dp_sw_o = (isel_i == 2'd2);

  AST_STROBE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reg_we_o)); // R9
  AST_STROBE_AFTER_PH2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|reg_we_o) |-> ($past(ph2_i, 2) && !$past(ph2_i))); // R1
  AST_LOAD_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_ld_o || dph_ld_o) |=> !(ir_ld_o || dph_ld_o)); // R8
  AST_RW_IN_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rw_n_o |-> $past(ph2_i)); // R4
  AST_RW_BUS_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rw_n_o |-> !be_ni); // R10
endmodule

// File: tb/wr_strobe_latch_tb.sv
module wr_strobe_latch_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, ph2 = 1'b0, inh = 1'b0, ir = 1'b0, dph = 1'b0, be_n = 1'b0;
  logic [3:0] wsel = '0;
  logic [1:0] isel = '0;
  logic [13:0] reg_we;
  logic [2:0] inc_we;
  logic ir_o, dph_o, rw_n, pc_sw, dp_sw;

  always #10 clk = ~clk;

  wr_strobe_latch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ph2_i(ph2), .wsel_i(wsel), .isel_i(isel),
    .inhpf_i(inh), .ir_ld_i(ir), .dph_ld_i(dph), .be_ni(be_n),
    .reg_we_o(reg_we), .inc_we_o(inc_we), .ir_ld_o(ir_o), .dph_ld_o(dph_o),
    .rw_n_o(rw_n), .pc_sw_o(pc_sw), .dp_sw_o(dp_sw));

  int checks = 0, failures = 0;
  string tag = "R11";
  bit done = 1'b0;

  // behavioural reference state
  int mp, ma, mcode, minh, misel, mir, mdph;
  logic [13:0] e_reg;
  logic [2:0]  e_inc;
  logic e_ir, e_dph;

  function automatic logic [13:0] reg_exp(int code, int ih);
    if (code < 1 || code > 14) return '0;
    if (code == 1 && ih != 0) return '0;   // R5
    return 14'(1) << (code - 1);
  endfunction

  function automatic logic [2:0] inc_exp(int s, int ih);
    if (s == 0) return '0;
    if (s == 1 && ih != 0) return '0;      // R5
    return 3'(1) << (s - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mp <= 0; ma <= 0; mcode <= 0; minh <= 0; misel <= 0; mir <= 0; mdph <= 0;
      e_reg <= '0; e_inc <= '0; e_ir <= 0; e_dph <= 0;
    end else begin
      e_reg <= '0; e_inc <= '0; e_ir <= 0; e_dph <= 0;
      if (ph2 && mp == 0) begin
        ma <= 1; mcode <= int'(wsel); minh <= int'(inh); misel <= int'(isel);
        mir <= int'(ir); mdph <= int'(dph);
      end else if (!ph2 && mp == 1) begin
        ma <= 0;
        e_reg <= reg_exp(mcode, minh);
        e_inc <= inc_exp(misel, minh);
        e_ir <= (mir != 0); e_dph <= (mdph != 0);
      end
      mp <= int'(ph2);
    end
  end

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #5;
    if (!done) begin
      logic e_rw;
      e_rw = !(ma == 1 && mcode == 15 && !be_n);
      check(reg_we === e_reg, "reg_we", int'(reg_we), int'(e_reg));
      check(inc_we === e_inc, "inc_we", int'(inc_we), int'(e_inc));
      check(ir_o === e_ir && dph_o === e_dph, "ir/dph load", int'({ir_o, dph_o}), int'({e_ir, e_dph}));
      check(rw_n === e_rw, "rw_n", int'(rw_n), int'(e_rw));
      check(pc_sw === (isel == 2'd1) && dp_sw === (isel == 2'd2), "sw",
            int'({pc_sw, dp_sw}), int'({isel == 2'd1, isel == 2'd2}));
      check($countones(reg_we) <= 1, "R9 onehot", int'(reg_we), 0);
    end
  end

  task automatic phase(int code, int s, bit ih, bit l_ir, bit l_dph, bit bn, int len, bit mutate);
    @(negedge clk);
    wsel = 4'(code); isel = 2'(s); inh = ih; ir = l_ir; dph = l_dph; be_n = bn; ph2 = 1'b1;
    @(negedge clk);
    if (mutate) begin   // R3: changes after capture must be ignored
      wsel = 4'(code ^ 5); inh = ~ih; ir = ~l_ir; dph = ~l_dph;
    end
    repeat (len - 1) @(negedge clk);
    ph2 = 1'b0;
    if (!mutate) begin wsel = '0; isel = '0; inh = 1'b0; ir = 1'b0; dph = 1'b0; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;                                   // R11 checked during reset
    tag = "R1";
    for (int c = 0; c < 16; c++) phase(c, 0, 0, 0, 0, 0, 1 + c % 3, 0);
    tag = "R2";  phase(15, 0, 0, 0, 0, 0, 2, 0);
    tag = "R4";  phase(15, 0, 0, 0, 0, 0, 5, 0);
    tag = "R10"; phase(15, 0, 0, 0, 0, 1, 3, 0);
    tag = "R10"; begin
      @(negedge clk); wsel = 4'd15; ph2 = 1'b1;
      repeat (2) @(negedge clk); be_n = 1'b1;
      repeat (2) @(negedge clk); be_n = 1'b0; ph2 = 1'b0;
      repeat (3) @(negedge clk); wsel = '0;
    end
    tag = "R5";  phase(1, 1, 1, 0, 0, 0, 2, 0);
    tag = "R5";  phase(1, 1, 0, 0, 0, 0, 2, 0);
    tag = "R7";  for (int s = 0; s < 4; s++) phase(3, s, 0, 0, 0, 0, 2, 0);
    tag = "R6";  for (int s = 0; s < 4; s++) phase(0, s, 1, 0, 0, 0, 1, 0);
    tag = "R8";  phase(0, 0, 0, 1, 0, 0, 2, 0);
    tag = "R8";  phase(7, 0, 0, 0, 1, 0, 3, 0);
    tag = "R3";  phase(6, 2, 0, 1, 0, 0, 4, 1);
    tag = "R3";  phase(15, 0, 1, 0, 1, 0, 3, 1);
    tag = "R9";  phase(14, 3, 0, 1, 1, 0, 2, 0);
    tag = "R11";
    @(negedge clk); rst_n = 1'b0; ph2 = 1'b1; wsel = 4'd15;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule